// File: doc/BRIEF.md
# Dual-Redundant Bus Message Selector

This block sits behind the receivers of two independent broadcast buses that carry the same TDMA round. For every slot of the round it is handed the copy from each bus in the same cycle, together with the slot position taken from the schedule. Each copy comes with a presence bit and a CRC verdict. The block forwards one validated copy per slot to downstream logic, prefers bus A when both copies are good, and falls back to bus B when the bus A copy is missing or corrupted.

Across rounds the block watches each bus. A bus that delivers no usable frame for several rounds in a row is declared permanently faulty, and its copies are ignored from then on, so reception runs on the twin bus alone. At the end of each round the block reports, per slot, whether that sender was heard on neither bus. It also counts slots where both copies were good but carried different payloads. Sensor slots occupy the low slot positions and actuator slots follow, and each forwarded message is tagged with its group.

Top module: `msel_top`

## Requirements
- R1: A copy is usable when its present bit and its CRC-ok bit are both 1, the slot index is below NUM_SENSOR+NUM_ACT, and its bus is not flagged faulty. When `slot_stb_i` is high and at least one copy is usable, `out_valid_o` is high in the following cycle with `out_slot_o` equal to the slot index and the chosen copy on `out_payload_o`. `out_valid_o` is low in every other cycle.
- R2: When both copies are usable, the bus A copy is forwarded and `out_bus_o` is 0.
- R3: When only the bus B copy is usable, because the bus A copy is absent or fails CRC, the bus B copy is forwarded and `out_bus_o` is 1.
- R4: A slot strobe with no usable copy produces no output.
- R5: When both copies are usable and their payloads differ, `mismatch_cnt_o` rises by one in the cycle after the strobe and saturates at its all-ones value (15 by default).
- R6: At each `round_end_i`, a bus that is not yet faulty and delivered no usable frame in that round advances its miss count; a usable frame resets the count to zero. When the count reaches FAULT_ROUNDS (default 3), that bus's bit of `bus_fault_o` (bit 0 = bus A, bit 1 = bus B) goes high in the cycle after the strobe. It then stays high until reset.
- R7: Copies from a bus flagged faulty are ignored even when they pass CRC. They are never forwarded and never count as a mismatch.
- R8: In the cycle `round_end_i` is high, bit s of `silent_o` is 1 for every slot s that had no usable copy since the last `round_start_i`, including a strobe in that same cycle. The value holds until `round_start_i`, and `silent_o` reads 0 from the cycle after `round_start_i`.
- R9: A strobe whose slot index is NUM_SENSOR+NUM_ACT or above is ignored. It gives no output, no mismatch count and no silent-flag update, and does not count as a usable frame for bus health.
- R10: `out_actuator_o` is 1 for a forwarded slot whose index is NUM_SENSOR or above, and 0 for the sensor slots below it.
- R11: After reset, `out_valid_o`, `silent_o`, `bus_fault_o` and `mismatch_cnt_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| round_start_i | input | 1 | Start-of-round strobe |
| round_end_i | input | 1 | End-of-round strobe |
| slot_stb_i | input | 1 | Both bus copies of one slot are on the inputs |
| slot_idx_i | input | SLOT_W (4) | Slot position in the round |
| a_present_i | input | 1 | Bus A delivered a frame in this slot |
| a_crc_ok_i | input | 1 | Bus A frame passed CRC |
| a_payload_i | input | PAYLOAD_W (16) | Bus A payload |
| b_present_i | input | 1 | Bus B delivered a frame in this slot |
| b_crc_ok_i | input | 1 | Bus B frame passed CRC |
| b_payload_i | input | PAYLOAD_W (16) | Bus B payload |
| out_valid_o | output | 1 | A validated message is on the outputs |
| out_slot_o | output | SLOT_W (4) | Slot of the forwarded message |
| out_payload_o | output | PAYLOAD_W (16) | Forwarded payload |
| out_bus_o | output | 1 | Source bus: 0 = A, 1 = B |
| out_actuator_o | output | 1 | Forwarded slot belongs to the actuator group |
| silent_o | output | NSLOT (11) | Per-slot silent-sender flags |
| bus_fault_o | output | 2 | Permanent fault flags, bit 0 = A, bit 1 = B |
| mismatch_cnt_o | output | MISM_W (4) | Saturating count of good-copy payload disagreements |

## Verification
A forwarded message and the mismatch count are registered, so they are due one cycle after the slot strobe. The silent flags are due in the very cycle of the end-of-round strobe, and a bus fault flag one cycle after it. The driver applies every strobe at a falling edge, and the scoreboard monitor compares the queued expectation at the next falling edge. The silent vector is sampled one nanosecond after `round_end_i` is raised, then again after it drops to confirm the hold, and once more after the next round start to confirm the clear.

// File: rtl/msel_pkg.sv
package msel_pkg;

    typedef enum logic {
        BUS_A = 1'b0,
        BUS_B = 1'b1
    } bus_sel_e;

    localparam int NUM_BUS = 2;

endpackage

// File: rtl/msel_lane_qual.sv
module msel_lane_qual #(
    parameter int SLOT_W = 4,
    parameter int NSLOT  = 11
) (
    input  logic              stb_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              present_i,
    input  logic              crc_ok_i,
    input  logic              bus_fault_i,
    output logic              usable_o
);

    logic in_range;

    always_comb begin
        in_range = (32'(slot_i) < NSLOT);
        usable_o = stb_i && in_range && present_i && crc_ok_i && !bus_fault_i;
    end

endmodule

// File: rtl/msel_bus_health.sv
module msel_bus_health #(
    parameter int FAULT_ROUNDS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic round_start_i,
    input  logic round_end_i,
    input  logic usable_i,
    output logic fault_o
);

    localparam int CNT_W = $clog2(FAULT_ROUNDS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] miss;
        logic             heard;
        logic             fault;
    } health_t;

    health_t st_d, st_q;
    logic    heard_now;

    always_comb begin
        st_d      = st_q;
        heard_now = st_q.heard;
        if (round_start_i) begin
            heard_now = 1'b0;
        end
        if (usable_i) begin
            heard_now = 1'b1;
        end
        st_d.heard = heard_now;
        if (round_end_i) begin
            st_d.heard = 1'b0;
            if (!st_q.fault) begin
                if (heard_now) begin
                    st_d.miss = '0;
                end else begin
                    st_d.miss = st_q.miss + 1'b1;
                    if (32'(st_q.miss) + 1 >= FAULT_ROUNDS) begin
                        st_d.fault = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o = st_q.fault;

endmodule

// File: rtl/msel_slot_track.sv
module msel_slot_track #(
    parameter int NSLOT  = 11,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              round_start_i,
    input  logic              round_end_i,
    input  logic              mark_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [NSLOT-1:0]  silent_o
);

    typedef struct packed {
        logic [NSLOT-1:0] seen;
        logic [NSLOT-1:0] hold;
    } track_t;

    track_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (round_start_i) begin
            st_d.seen = '0;
            st_d.hold = '0;
        end
        for (int s = 0; s < NSLOT; s++) begin
            if (mark_i && (32'(slot_i) == s)) begin
                st_d.seen[s] = 1'b1;
            end
        end
        if (round_end_i) begin
            st_d.hold = ~st_d.seen;
        end
        silent_o = round_end_i ? ~st_d.seen : st_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/msel_top.sv
module msel_top
    import msel_pkg::*;
#(
    parameter int PAYLOAD_W    = 16,
    parameter int NUM_SENSOR   = 4,
    parameter int NUM_ACT      = 7,
    parameter int FAULT_ROUNDS = 3,
    parameter int MISM_W       = 4,
    localparam int NSLOT       = NUM_SENSOR + NUM_ACT,
    localparam int SLOT_W      = $clog2(NSLOT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 round_start_i,
    input  logic                 round_end_i,
    input  logic                 slot_stb_i,
    input  logic [SLOT_W-1:0]    slot_idx_i,
    input  logic                 a_present_i,
    input  logic                 a_crc_ok_i,
    input  logic [PAYLOAD_W-1:0] a_payload_i,
    input  logic                 b_present_i,
    input  logic                 b_crc_ok_i,
    input  logic [PAYLOAD_W-1:0] b_payload_i,
    output logic                 out_valid_o,
    output logic [SLOT_W-1:0]    out_slot_o,
    output logic [PAYLOAD_W-1:0] out_payload_o,
    output logic                 out_bus_o,
    output logic                 out_actuator_o,
    output logic [NSLOT-1:0]     silent_o,
    output logic [1:0]           bus_fault_o,
    output logic [MISM_W-1:0]    mismatch_cnt_o
);

    localparam logic [MISM_W-1:0] MISM_MAX = {MISM_W{1'b1}};

    typedef struct packed {
        logic                 valid;
        logic [SLOT_W-1:0]    slot;
        logic [PAYLOAD_W-1:0] payload;
        bus_sel_e             bus;
        logic                 act;
        logic [MISM_W-1:0]    mism;
    } out_t;

    logic [NUM_BUS-1:0]                present;
    logic [NUM_BUS-1:0]                crc_ok;
    logic [NUM_BUS-1:0][PAYLOAD_W-1:0] payload;
    logic [NUM_BUS-1:0]                usable;
    logic [NUM_BUS-1:0]                fault;
    logic                              any_usable;

    out_t out_d, out_q;

    assign present = {b_present_i, a_present_i};
    assign crc_ok  = {b_crc_ok_i, a_crc_ok_i};
    assign payload = {b_payload_i, a_payload_i};

    for (genvar g = 0; g < NUM_BUS; g++) begin : g_lane
        msel_lane_qual #(
            .SLOT_W (SLOT_W),
            .NSLOT  (NSLOT)
        ) qual_i (
            .stb_i       (slot_stb_i),
            .slot_i      (slot_idx_i),
            .present_i   (present[g]),
            .crc_ok_i    (crc_ok[g]),
            .bus_fault_i (fault[g]),
            .usable_o    (usable[g])
        );

        msel_bus_health #(
            .FAULT_ROUNDS (FAULT_ROUNDS)
        ) health_i (
            .clk           (clk),
            .rst_n         (rst_n),
            .round_start_i (round_start_i),
            .round_end_i   (round_end_i),
            .usable_i      (usable[g]),
            .fault_o       (fault[g])
        );
    end

    assign any_usable = |usable;

    msel_slot_track #(
        .NSLOT  (NSLOT),
        .SLOT_W (SLOT_W)
    ) track_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .round_start_i (round_start_i),
        .round_end_i   (round_end_i),
        .mark_i        (any_usable),
        .slot_i        (slot_idx_i),
        .silent_o      (silent_o)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = any_usable;
        if (any_usable) begin
            out_d.slot = slot_idx_i;
            out_d.act  = (32'(slot_idx_i) >= NUM_SENSOR);
            if (usable[0]) begin
                out_d.bus     = BUS_A;
                out_d.payload = payload[0];
            end else begin
                out_d.bus     = BUS_B;
                out_d.payload = payload[1];
            end
        end
        if (usable[0] && usable[1] && (payload[0] != payload[1])
            && (out_q.mism != MISM_MAX)) begin
            out_d.mism = out_q.mism + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid_o    = out_q.valid;
    assign out_slot_o     = out_q.slot;
    assign out_payload_o  = out_q.payload;
    assign out_bus_o      = out_q.bus;
    assign out_actuator_o = out_q.act;
    assign mismatch_cnt_o = out_q.mism;
    assign bus_fault_o    = fault;

endmodule

// File: rtl/msel_chk.sv
module msel_chk #(
    parameter int NSLOT  = 11,
    parameter int SLOT_W = 4,
    parameter int MISM_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              round_start_i,
    input logic              round_end_i,
    input logic              slot_stb_i,
    input logic [SLOT_W-1:0] slot_idx_i,
    input logic              out_valid_o,
    input logic              out_bus_o,
    input logic [NSLOT-1:0]  silent_o,
    input logic [1:0]        bus_fault_o,
    input logic [MISM_W-1:0] mismatch_cnt_o
);

    AST_OUT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(slot_stb_i)); // R1

    AST_RANGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(slot_stb_i && (32'(slot_idx_i) >= NSLOT)) |-> !out_valid_o); // R9

    AST_MISM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch_cnt_o != $past(mismatch_cnt_o))
        |-> (mismatch_cnt_o == $past(mismatch_cnt_o) + 1'b1)); // R5

    AST_FAULT_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fault_o[0] |=> bus_fault_o[0]); // R6

    AST_FAULT_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fault_o[1] |=> bus_fault_o[1]); // R6

    AST_FAULT_A_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_fault_o[0]) |-> $past(round_end_i)); // R6

    AST_FAULT_B_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_fault_o[1]) |-> $past(round_end_i)); // R6

    AST_SKIP_FAULTY_A: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && $past(bus_fault_o[0])) |-> out_bus_o); // R7

    AST_SKIP_FAULTY_B: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && $past(bus_fault_o[1])) |-> !out_bus_o); // R7

    AST_SILENT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(round_start_i) && !round_end_i) |-> (silent_o == '0)); // R8

endmodule

bind msel_top msel_chk #(
    .NSLOT  (NSLOT),
    .SLOT_W (SLOT_W),
    .MISM_W (MISM_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .round_start_i  (round_start_i),
    .round_end_i    (round_end_i),
    .slot_stb_i     (slot_stb_i),
    .slot_idx_i     (slot_idx_i),
    .out_valid_o    (out_valid_o),
    .out_bus_o      (out_bus_o),
    .silent_o       (silent_o),
    .bus_fault_o    (bus_fault_o),
    .mismatch_cnt_o (mismatch_cnt_o)
);

// File: tb/msel_top_tb_top.sv
module msel_top_tb_top;

    localparam int PW  = 16;
    localparam int NS  = 4;
    localparam int NA  = 7;
    localparam int FR  = 3;
    localparam int MW  = 4;
    localparam int NSL = NS + NA;
    localparam int SW  = $clog2(NSL);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           round_start_i = 1'b0;
    logic           round_end_i = 1'b0;
    logic           slot_stb_i = 1'b0;
    logic [SW-1:0]  slot_idx_i = '0;
    logic           a_present_i = 1'b0;
    logic           a_crc_ok_i = 1'b0;
    logic [PW-1:0]  a_payload_i = '0;
    logic           b_present_i = 1'b0;
    logic           b_crc_ok_i = 1'b0;
    logic [PW-1:0]  b_payload_i = '0;
    logic           out_valid_o;
    logic [SW-1:0]  out_slot_o;
    logic [PW-1:0]  out_payload_o;
    logic           out_bus_o;
    logic           out_actuator_o;
    logic [NSL-1:0] silent_o;
    logic [1:0]     bus_fault_o;
    logic [MW-1:0]  mismatch_cnt_o;

    always #5 clk = ~clk;

    msel_top #(
        .PAYLOAD_W (PW), .NUM_SENSOR (NS), .NUM_ACT (NA),
        .FAULT_ROUNDS (FR), .MISM_W (MW)
    ) dut_i (.*);

    typedef struct {
        int    slot;
        int    pay;
        int    bus;
        int    act;
        string tag;
    } exp_t;

    exp_t           sb_q[$];
    int             total = 0;
    int             bad = 0;
    bit             done = 0;
    int             mism_m = 0;
    bit [1:0]       fault_m = '0;
    int             miss_m[2] = '{0, 0};
    bit [1:0]       heard_m = '0;
    bit [NSL-1:0]   seen_m = '0;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // driver: one strobe, expectation pushed from the requirement model
    task automatic send_slot(input int slot, input bit ap, input bit aok, input int apay,
                             input bit bp, input bit bok, input int bpay, input string tag);
        bit ua, ub;
        exp_t e;
        @(negedge clk);
        slot_stb_i  = 1'b1;
        slot_idx_i  = SW'(slot);
        a_present_i = ap; a_crc_ok_i = aok; a_payload_i = PW'(apay);
        b_present_i = bp; b_crc_ok_i = bok; b_payload_i = PW'(bpay);
        ua = ap && aok && !fault_m[0] && (slot < NSL);
        ub = bp && bok && !fault_m[1] && (slot < NSL);
        if (ua) heard_m[0] = 1'b1;
        if (ub) heard_m[1] = 1'b1;
        if (ua || ub) begin
            seen_m[slot] = 1'b1;
            e.slot = slot;
            e.pay  = ua ? apay : bpay;
            e.bus  = ua ? 0 : 1;
            e.act  = (slot >= NS) ? 1 : 0;
            e.tag  = tag;
            sb_q.push_back(e);
        end
        if (ua && ub && (apay != bpay) && (mism_m < 15)) mism_m++;
        @(negedge clk);
        slot_stb_i = 1'b0;
    endtask

    task automatic begin_round();
        @(negedge clk);
        round_start_i = 1'b1;
        seen_m  = '0;
        heard_m = '0;
        @(negedge clk);
        round_start_i = 1'b0;
        check("R8 silent cleared after round start", int'(silent_o), 0);
    endtask

    task automatic end_round();
        bit [NSL-1:0] exp_sil;
        @(negedge clk);
        round_end_i = 1'b1;
        exp_sil = ~seen_m;
        #1;
        check("R8 silent at round end", int'(silent_o), int'(exp_sil));
        for (int b = 0; b < 2; b++) begin
            if (!fault_m[b]) begin
                if (heard_m[b]) miss_m[b] = 0;
                else begin
                    miss_m[b]++;
                    if (miss_m[b] >= FR) fault_m[b] = 1'b1;
                end
            end
        end
        heard_m = '0;
        @(negedge clk);
        round_end_i = 1'b0;
        check("R6 bus fault flags", int'(bus_fault_o), int'(fault_m));
        check("R8 silent held", int'(silent_o), int'(exp_sil));
    endtask

    // monitor: compare each produced message against the queue head
    always @(negedge clk) begin
        if (rst_n && out_valid_o) begin
            if (sb_q.size() == 0) begin
                check("R4 R9 unexpected output", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " R1 slot"}, int'(out_slot_o), e.slot);
                check({e.tag, " R1 payload"}, int'(out_payload_o), e.pay);
                check({e.tag, " bus select"}, int'(out_bus_o), e.bus);
                check("R10 actuator tag", int'(out_actuator_o), e.act);
            end
        end
    end

    initial begin
        #1_000_000;
        check("watchdog expired", 1, 0);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset valid", int'(out_valid_o), 0);
        check("R11 reset silent", int'(silent_o), 0);
        check("R11 reset fault", int'(bus_fault_o), 0);
        check("R11 reset mismatch", int'(mismatch_cnt_o), 0);
        rst_n = 1'b1;

        // both buses clean
        begin_round();
        for (int s = 0; s < NSL; s++) send_slot(s, 1, 1, 'h1000 + s, 1, 1, 'h1000 + s, "R2");
        end_round();

        // fallback, empty slot, mismatch, out-of-range
        begin_round();
        send_slot(0, 1, 0, 'h0A, 1, 1, 'h0B, "R3");
        send_slot(1, 0, 1, 'h0C, 1, 1, 'h0D, "R3");
        send_slot(2, 1, 0, 'h0E, 0, 1, 'h0F, "R4");
        check("R4 no output", int'(out_valid_o), 0);
        send_slot(3, 1, 1, 'h1111, 1, 1, 'h2222, "R5");
        check("R5 mismatch count", int'(mismatch_cnt_o), mism_m);
        send_slot(15, 1, 1, 'h3333, 1, 1, 'h4444, "R9");
        check("R9 no output", int'(out_valid_o), 0);
        check("R9 mismatch unchanged", int'(mismatch_cnt_o), mism_m);
        send_slot(7, 1, 1, 'h0777, 1, 1, 'h0777, "R2");
        end_round();

        // saturation of the mismatch count
        begin_round();
        for (int i = 0; i < 16; i++) send_slot(4, 1, 1, i, 1, 1, i ^ 'hFFFF, "R5");
        check("R5 saturated count", int'(mismatch_cnt_o), 15);
        end_round();

        // bus B silent for FR rounds
        for (int r = 0; r < FR; r++) begin
            begin_round();
            for (int s = 0; s < NSL; s++) send_slot(s, 1, 1, 'h2000 + s, 0, 0, 0, "R2");
            end_round();
        end
        check("R6 bus B faulty", int'(bus_fault_o), 2);

        begin_round();
        send_slot(0, 1, 1, 'h3000, 1, 1, 'h3001, "R7");
        send_slot(1, 0, 0, 0, 1, 1, 'h3002, "R7");
        check("R7 faulty bus copy ignored", int'(out_valid_o), 0);
        end_round();

        // bus A: two misses, a hit resets, two misses, then the fault
        for (int r = 0; r < 2; r++) begin
            begin_round();
            send_slot(0, 0, 0, 0, 1, 1, 'h5000, "R7");
            end_round();
        end
        begin_round();
        send_slot(0, 1, 1, 'h5100, 0, 0, 0, "R6");
        end_round();
        for (int r = 0; r < 2; r++) begin
            begin_round();
            end_round();
        end
        check("R6 miss count reset by hit", int'(bus_fault_o), 2);
        begin_round();
        end_round();
        check("R6 bus A faulty", int'(bus_fault_o), 3);
        begin_round();
        send_slot(5, 1, 1, 'h6000, 1, 1, 'h6000, "R7");
        check("R7 both buses faulty", int'(out_valid_o), 0);
        end_round();

        repeat (3) @(negedge clk);
        check("R1 scoreboard drained", sb_q.size(), 0);
        finish_up();
    end

endmodule